// File: doc/BRIEF.md
# Two-Wire Indexed Register Slave

This block is a slave on a two-wire SMBus-style bus, sampled by a faster system clock. It holds a small bank of 8-bit control registers. It exports the fields of those registers to the clock-distribution control logic beside it: power-down and stop drive modes, polarity, bandwidth, bypass and divider selects, per-output enables and per-output stoppable flags. The bus side is the only data path. It has no stream interface and no back-pressure, and the slave never stretches SCL. The block keeps up with the bus purely by oversampling it, so no valid/ready handshake is needed. All configuration and status pins are plain levels.

A host writes by sending the write address byte, a starting index, a byte count and then that many data bytes. The bytes land in consecutive registers. A host reads by sending the write address and an index, then a repeated start and the read address byte. The slave answers with the content of its count register and then consecutive registers from the index onward, until the host answers a byte with NACK. A start or stop condition seen at any moment abandons whatever transfer was in progress.

Top module: `smb_idx_regs`

## Requirements
- R1: After reset the bank holds: index 0 = 0x07, index 1 = 0xFF, index 2 = 0x00, index 3 = 0x00, index 4 = {REV_ID, 4'b0001} (0x01 by default), index 5 = DEV_ID (0x83 by default), index 6 = 0x07.
- R2: The slave acknowledges address byte 0xDC (write) and 0xDD (read). For any other address byte it returns NACK and leaves SDA released until the next start condition.
- R3: A write transfer consists of 0xDC, index N, count X and then data bytes. Each byte is acknowledged by the slave, and data byte k is stored in register N+k for k < X.
- R4: Data bytes sent beyond the count X are acknowledged and discarded.
- R5: A read transfer consists of 0xDC, index N, a repeated start, then 0xDD. The slave sends the index 6 value first and then registers N, N+1, ... in turn. It keeps sending while the host acknowledges, and releases SDA after the host's NACK.
- R6: Index 6 is writable, and the first byte of each read returns its current value.
- R7: Writes to index 3, to the read-only index 4 and to indices 7 and above are acknowledged but change nothing. Reads of index 3 and of indices 7 and above return 0x00.
- R8: Configuration outputs follow the registers. Index 0 bit 7 drives pd_tristate, bit 6 stop_tristate, bit 5 pd_active_high, bit 2 bw_low, bit 1 pll_mode and bit 0 div_full; bits 4:3 are stored only. Index 1 drives out_enable and index 2 drives stop_allow, with output i on bit i.
- R9: A stop condition mid-byte abandons the transfer without writing the partial byte. A later start begins again at the address phase.
- R10: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pd_tristate | output | 1 | Power-down leaves outputs undriven when 1 |
| stop_tristate | output | 1 | Stopped outputs undriven when 1 |
| pd_active_high | output | 1 | Power-down pin polarity select |
| bw_low | output | 1 | 1 selects low loop bandwidth |
| pll_mode | output | 1 | 1 selects loop mode, 0 fan-out bypass |
| div_full | output | 1 | 1 passes input rate, 0 halves it |
| out_enable | output | N_OUT | Per-output enable |
| stop_allow | output | N_OUT | Per-output stoppable flag |

## Verification
The assertions assume a well-behaved bus. SDA changes only while SCL is low, except for start and stop conditions. Every SCL high and low phase lasts several system clocks, which covers the two-flop synchronizer and the edge detector. No host forms a stop or start while the slave is pulling SDA low. The bench builds every bus phase from quarter periods of six system clocks. It changes SDA only in the low phase, and it aborts transfers only during host-driven bits, so random index, count, overrun and data choices all stay inside these assumptions.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int NREG    = 7;
  localparam int IDX_RSV = 3;
  localparam int IDX_ID  = 4;
  localparam int IDX_CNT = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR, K_IDX, K_CNT, K_DATA
  } rx_kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_d,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank import smb_pkg::*; #(
  parameter int         N_OUT  = 8,
  parameter logic [3:0] REV_ID = 4'h0,
  parameter logic [7:0] DEV_ID = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       widx,
  input  logic [7:0]       wdata,
  input  logic [7:0]       ridx,
  output logic [7:0]       rdata,
  output logic [2:0]       mode_hi,
  output logic [2:0]       mode_lo,
  output logic [N_OUT-1:0] en,
  output logic [N_OUT-1:0] stp
);
  logic [7:0] regs [NREG];

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      0:       rst_val = 8'h07;
      1:       rst_val = 8'hFF;
      5:       rst_val = DEV_ID;
      IDX_CNT: rst_val = 8'h07;
      default: rst_val = 8'h00;
    endcase
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_RSV) begin : g_rsv
      assign regs[i] = 8'h00;
    end else if (i == IDX_ID) begin : g_id
      assign regs[i] = {REV_ID, 4'b0001};
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       regs[i] <= rst_val(i);
        else if (we && widx == 8'(i))     regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ridx == 8'(i)) rdata = regs[i];
  end

  assign mode_hi = regs[0][7:5];
  assign mode_lo = regs[0][2:0];
  assign en      = regs[1][N_OUT-1:0];
  assign stp     = regs[2][N_OUT-1:0];

  // R7
  ro_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx >= 8'(NREG)) |=> (rdata == $past(rdata) || ridx != $past(ridx)));
endmodule

// File: rtl/smb_engine.sv
module smb_engine import smb_pkg::*; #(
  parameter logic [6:0] ADDR7 = 7'h6E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_d,
  input  logic       sda_s,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic [7:0] rdata,
  output logic [7:0] rd_idx,
  output logic       we,
  output logic [7:0] widx,
  output logic [7:0] wdata,
  output logic       sda_oe
);
  smb_state_e state;
  rx_kind_e   kind;
  logic [7:0] sh, ptr, wleft;
  logic [3:0] bitc;
  logic       rd_mode, host_nak;
  logic       byte_done;

  assign byte_done = (state == ST_RX) && scl_fall && (bitc == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      sh       <= 8'h00;
      ptr      <= 8'h00;
      wleft    <= 8'h00;
      bitc     <= 4'd0;
      rd_mode  <= 1'b0;
      host_nak <= 1'b0;
    end else if (start_ev) begin
      state <= ST_RX;
      kind  <= K_ADDR;
      bitc  <= 4'd0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bitc != 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (byte_done) begin
            bitc <= 4'd0;
            case (kind)
              K_ADDR: begin
                if (sh[7:1] == ADDR7) begin
                  state   <= ST_RACK;
                  rd_mode <= sh[0];
                  kind    <= K_IDX;
                end else begin
                  state <= ST_SKIP;
                end
              end
              K_IDX: begin
                ptr   <= sh;
                kind  <= K_CNT;
                state <= ST_RACK;
              end
              K_CNT: begin
                wleft <= sh;
                kind  <= K_DATA;
                state <= ST_RACK;
              end
              default: begin
                if (wleft != 8'd0) begin
                  ptr   <= ptr + 8'd1;
                  wleft <= wleft - 8'd1;
                end
                state <= ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              state <= ST_TX;
              sh    <= rdata;
              bitc  <= 4'd0;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitc == 4'd7) begin
              state <= ST_TACK;
              bitc  <= 4'd0;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              bitc <= bitc + 4'd1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) host_nak <= sda_s;
          if (scl_fall) begin
            if (host_nak) begin
              state <= ST_SKIP;
            end else begin
              state <= ST_TX;
              sh    <= rdata;
              ptr   <= ptr + 8'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_idx = (state == ST_RACK) ? 8'(IDX_CNT) : ptr;
  assign we     = byte_done && (kind == K_DATA) && (wleft != 8'd0);
  assign widx   = ptr;
  assign wdata  = sh;
  assign sda_oe = (state == ST_RACK) || (state == ST_TX && !sh[7]);

  // R10
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_d);
  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && $past(state) == ST_RX && $past(kind) == K_ADDR)
      |-> ($past(sh[7:1]) == ADDR7));
  // R4
  wr_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (wleft == $past(wleft) - 8'd1));
  // R9
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE));
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_RX && kind == K_ADDR && bitc == 4'd0));
  // R5
  nak_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TACK && scl_fall && host_nak) |=> (state == ST_SKIP && !sda_oe));
endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs import smb_pkg::*; #(
  parameter int         N_OUT  = 8,
  parameter int         SYNC   = 2,
  parameter logic [6:0] ADDR7  = 7'h6E,
  parameter logic [3:0] REV_ID = 4'h0,
  parameter logic [7:0] DEV_ID = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             pd_tristate,
  output logic             stop_tristate,
  output logic             pd_active_high,
  output logic             bw_low,
  output logic             pll_mode,
  output logic             div_full,
  output logic [N_OUT-1:0] out_enable,
  output logic [N_OUT-1:0] stop_allow
);
  logic scl_s, scl_d, sda_s, start_ev, stop_ev, scl_rise, scl_fall;
  logic we;
  logic [7:0] widx, wdata, rd_idx, rdata;
  logic [2:0] mode_hi, mode_lo;

  smb_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_d(scl_d), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  smb_engine #(.ADDR7(ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_d(scl_d), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rdata(rdata), .rd_idx(rd_idx), .we(we), .widx(widx),
    .wdata(wdata), .sda_oe(sda_oe)
  );

  smb_regbank #(.N_OUT(N_OUT), .REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
    .ridx(rd_idx), .rdata(rdata), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .en(out_enable), .stp(stop_allow)
  );

  assign {pd_tristate, stop_tristate, pd_active_high} = mode_hi;
  assign {bw_low, pll_mode, div_full}                 = mode_lo;

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(stop_ev)) |-> !sda_oe);
endmodule

// File: tb/sim_smb_idx_regs.sv
module sim_smb_idx_regs;
  localparam int CLK_NS = 10;
  localparam int Q      = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_line, sda_oe;
  logic pd_tristate, stop_tristate, pd_active_high, bw_low, pll_mode, div_full;
  logic [7:0] out_enable, stop_allow;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m [7];
  bit oe_seen = 0;
  int r10_bad = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  assign sda_line = sda_h & ~sda_oe;
  always #(CLK_NS/2) clk = ~clk;

  smb_idx_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pd_tristate(pd_tristate), .stop_tristate(stop_tristate),
    .pd_active_high(pd_active_high), .bw_low(bw_low), .pll_mode(pll_mode),
    .div_full(div_full), .out_enable(out_enable), .stop_allow(stop_allow)
  );

  always @(negedge clk) begin
    if (sda_oe) oe_seen <= 1'b1;
    if (rst_n && scl && scl_prev && sda_oe !== oe_prev) r10_bad++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] i);
    return (i < 8'd7) ? m[i] : 8'h00;
  endfunction

  function automatic void mwr(input logic [7:0] i, input logic [7:0] d);
    if (i < 8'd7 && i != 8'd3 && i != 8'd4) m[i] = d;
  endfunction

  task automatic bus_start();
    sda_h = 1; wq(); scl = 1; wq(); sda_h = 0; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 0; wq(); scl = 1; wq(); sda_h = 1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_h = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_h = 1; wq(); scl = 1; wq();
    ack = ~sda_line;
    wq(); scl = 0; wq();
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] b);
    sda_h = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1; wq(); b = {b[6:0], sda_line}; wq(); scl = 0;
    end
    sda_h = nak; wq(); scl = 1; wq(); wq(); scl = 0; sda_h = 1; wq();
  endtask

  task automatic blk_write(input logic [7:0] n, input logic [7:0] x,
                           input int nb, input logic [7:0] d [8]);
    logic ack;
    bus_start();
    send_byte(8'hDC, ack); chk("R2 write address ack", ack, 1);
    send_byte(n, ack);     chk("R3 index ack", ack, 1);
    send_byte(x, ack);     chk("R3 count ack", ack, 1);
    for (int k = 0; k < nb; k++) begin
      send_byte(d[k], ack);
      chk((k < int'(x)) ? "R3 data ack" : "R4 overrun ack", ack, 1);
      if (k < int'(x)) mwr(n + 8'(k), d[k]);
    end
    bus_stop();
  endtask

  task automatic blk_read(input string tag, input logic [7:0] n, input int nb);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, ack); chk("R5 write address ack", ack, 1);
    send_byte(n, ack);     chk("R5 index ack", ack, 1);
    sda_h = 1; wq(); scl = 1; wq(); sda_h = 0; wq(); scl = 0; wq();
    send_byte(8'hDD, ack); chk("R2 read address ack", ack, 1);
    recv_byte(1'b0, b);    chk("R6 count byte", b, m[6]);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k == nb - 1, b);
      chk(tag, b, exp_rd(n + 8'(k)));
    end
    chk("R5 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic chk_ports(input string tag);
    chk(tag, {pd_tristate, stop_tristate, pd_active_high, bw_low, pll_mode, div_full},
        {m[0][7:5], m[0][2:0]});
    chk(tag, out_enable, m[1]);
    chk(tag, stop_allow, m[2]);
  endtask

  initial begin
    logic [7:0] d [8];
    logic ack;
    void'($urandom(32'd2024));
    m[0] = 8'h07; m[1] = 8'hFF; m[2] = 8'h00; m[3] = 8'h00;
    m[4] = 8'h01; m[5] = 8'h83; m[6] = 8'h07;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 sda released", sda_oe, 0);
    chk_ports("R1 R8 reset ports");
    blk_read("R1 reset value", 8'd0, 7);

    // R2 foreign address
    bus_start();
    oe_seen = 0;
    send_byte(8'hA0, ack); chk("R2 foreign nack", ack, 0);
    send_byte(8'h01, ack); send_byte(8'h55, ack);
    chk("R2 never drives", oe_seen, 0);
    bus_stop();
    chk_ports("R2 no change");

    // R3 / R8
    d = '{8'h5A, 8'h3C, 0, 0, 0, 0, 0, 0};
    blk_write(8'd1, 8'd2, 2, d);
    chk_ports("R8 enables");
    // R4 overrun
    d = '{8'hF8, 8'h11, 0, 0, 0, 0, 0, 0};
    blk_write(8'd0, 8'd1, 2, d);
    chk_ports("R4 R8 overrun");
    blk_read("R4 overrun readback", 8'd0, 2);
    // R7 / R6
    d = '{8'hAA, 8'hBB, 8'h44, 8'h03, 8'h99, 0, 0, 0};
    blk_write(8'd3, 8'd5, 5, d);
    blk_read("R7 reserved and read-only", 8'd3, 6);

    // R9 stop mid-byte
    bus_start();
    send_byte(8'hDC, ack); send_byte(8'd1, ack); send_byte(8'd1, ack);
    send_bits(8'h00, 4);
    bus_stop();
    chk_ports("R9 partial byte dropped");
    blk_read("R9 restart after abort", 8'd1, 1);

    for (int it = 0; it < 16; it++) begin
      logic [7:0] n, x;
      int nb;
      n  = 8'($urandom_range(9, 0));
      x  = 8'($urandom_range(3, 0));
      nb = int'(x) + int'($urandom_range(1, 0));
      for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
      blk_write(n, x, nb, d);
      chk_ports("R8 random");
      blk_read("R5 random read", 8'($urandom_range(8, 0)), int'($urandom_range(3, 1)));
    end
    chk("R10 sda changes only while scl low", r10_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule